// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block keeps a circular list of receive buffer descriptors in a small local store and retires completed frames into it. Each entry holds a 16-bit status word, a 16-bit length and a 32-bit buffer pointer. An ownership flag in each status word tells whether the entry is free for hardware to fill. A ring-end flag closes the circle: after that entry the engine goes back to the base entry held in a base register.

The receive MAC reports each finished frame as a one-cycle pulse that carries the byte count and a group of error flags. If the current entry is owned by hardware, the engine writes the count and a rebuilt status word into it and returns the entry to software, all on one clock edge. It then moves to the next entry. If the current entry still belongs to software, the ring is full: the engine raises a sticky busy event and stops accepting frames. Software clears the event by writing one to its clear input, and it restarts reception with a separate restart pulse. Every frame turned away, whether by a full ring or by the halt, adds one to a saturating drop counter.

Software fills and re-arms entries through a write port and inspects them through a combinational read port.

Top module: `rxr_engine`

## Requirements
- R1: After reset, the current index, busy event, halt flag and drop counter are all zero, and every stored entry reads as zero.
- R2: A frame pulse that finds the current entry's ownership bit (status bit 15) set writes the entry on that clock edge. The length field takes the reported byte count unchanged, which includes the 4-byte FCS. The status becomes: bit 15 cleared, bit 11 (frame-complete) set, bit 13 (ring-end) kept as it was, bits [ERR_W-1:0] equal to the error flags, and all other bits zero.
- R3: After a written entry, the current index moves to the next entry. If that entry had its ring-end bit (bit 13) set, the index moves to the base index instead.
- R4: A frame with all error flags zero leaves status bits [ERR_W-1:0] zero. The buffer pointer of a written entry is never changed by the engine.
- R5: A frame pulse that finds the current entry's bit 15 clear sets both the busy event and the halt flag, and it leaves the entry and the current index unchanged.
- R6: While the halt flag is set, frame pulses change no entry and no index, and each one increments the drop counter. The frame that caused the halt is counted as well.
- R7: The drop counter stops at its all-ones value.
- R8: A busy-clear pulse clears the busy event and leaves the halt flag set.
- R9: A restart pulse clears the halt flag. The next frame is then retried on the same current entry.
- R10: A base-register write loads both the base index and the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software entry write strobe |
| sw_idx | input | IDX_W | Entry index for software write |
| sw_status | input | 16 | Status word to write |
| sw_len | input | 16 | Length word to write |
| sw_ptr | input | 32 | Buffer pointer to write |
| sw_rd_idx | input | IDX_W | Entry index for software read |
| sw_rd_status | output | 16 | Status of the entry being read |
| sw_rd_len | output | 16 | Length of the entry being read |
| sw_rd_ptr | output | 32 | Pointer of the entry being read |
| base_we | input | 1 | Base register write strobe |
| base_idx | input | IDX_W | New base index |
| busy_clr | input | 1 | Write-one-to-clear for the busy event |
| halt_clr | input | 1 | Restart pulse that clears the halt |
| frm_valid | input | 1 | One-cycle frame completion pulse |
| frm_len | input | 16 | Frame byte count, FCS included |
| frm_err | input | ERR_W | Frame error flags |
| cur_idx | output | IDX_W | Index of the current entry |
| busy_evt | output | 1 | Sticky ring-full event |
| halted | output | 1 | Reception halted |
| drop_cnt | output | DROP_W | Saturating count of turned-away frames |

## Verification
The assertions assume that software never writes the entry the engine is completing in the same cycle, and that a base write never coincides with a frame pulse. The write-back check also assumes that frame pulses last one cycle. The directed stimulus drives every software access and every frame pulse in separate cycles, one negative edge apart. It re-arms an entry only after the engine has left that entry or while the engine is halted, so the ownership hand-off is never contested.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int OWN_BIT  = 15;
  localparam int END_BIT  = 13;
  localparam int DONE_BIT = 11;

  typedef struct packed {
    logic [15:0] status;
    logic [15:0] len;
    logic [31:0] ptr;
  } rxr_desc_t;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
  import rxr_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [IDX_W-1:0] sw_idx,
  input  rxr_desc_t        sw_wdata,
  input  logic             wb_we,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [15:0]      wb_status,
  input  logic [15:0]      wb_len,
  input  logic [IDX_W-1:0] eng_idx,
  output logic [15:0]      eng_status,
  input  logic [IDX_W-1:0] rd_idx,
  output rxr_desc_t        rd_data
);
  rxr_desc_t ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    rxr_desc_t ent_d;
    logic      ent_en;

    always_comb begin
      ent_en = 1'b0;
      ent_d  = ent_q[g];
      if (wb_we && wb_idx == IDX_W'(g)) begin
        ent_en        = 1'b1;
        ent_d.status  = wb_status;
        ent_d.len     = wb_len;
      end else if (sw_we && sw_idx == IDX_W'(g)) begin
        ent_en = 1'b1;
        ent_d  = sw_wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[g] <= '0;
      else if (ent_en) ent_q[g] <= ent_d;
    end
  end

  assign eng_status = ent_q[eng_idx].status;
  assign rd_data    = ent_q[rd_idx];

  // R2: a completed entry is handed to software (ownership bit clear)
  p_wb_releases_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |=> !ent_q[$past(wb_idx)].status[OWN_BIT]);
  // R4: the engine never alters a buffer pointer
  p_ptr_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_we && !sw_we) |=> $stable(ent_q[$past(wb_idx)].ptr));
endmodule

// File: rtl/rxr_drop_ctr.sv
module rxr_drop_ctr #(
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drop_evt,
  output logic [DROP_W-1:0] drop_cnt
);
  localparam logic [DROP_W-1:0] CNT_MAX = '1;

  logic [DROP_W-1:0] cnt_q, cnt_d;
  logic              cnt_en;

  always_comb begin
    cnt_en = drop_evt && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign drop_cnt = cnt_q;

  // R7: saturated count stays put
  p_drop_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  // R6: each turned-away frame below saturation adds exactly one
  p_drop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/rxr_ctrl.sv
module rxr_ctrl
  import rxr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ERR_W = 6,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [IDX_W-1:0] base_idx,
  input  logic             busy_clr,
  input  logic             halt_clr,
  input  logic             frm_valid,
  input  logic [15:0]      frm_len,
  input  logic [ERR_W-1:0] frm_err,
  input  logic [15:0]      cur_status,
  output logic             wb_we,
  output logic [15:0]      wb_status,
  output logic [15:0]      wb_len,
  output logic [IDX_W-1:0] cur_idx,
  output logic             busy_evt,
  output logic             halted,
  output logic             drop_evt
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] base_q, base_d, cur_q, cur_d;
  logic             halt_q, halt_d, busy_q, busy_d;
  logic             accept, full_hit;

  always_comb begin
    accept   = frm_valid && !halt_q &&  cur_status[OWN_BIT];
    full_hit = frm_valid && !halt_q && !cur_status[OWN_BIT];
    drop_evt = frm_valid && (halt_q || !cur_status[OWN_BIT]);

    wb_we     = accept;
    wb_len    = frm_len;
    wb_status = '0;
    wb_status[END_BIT]     = cur_status[END_BIT];
    wb_status[DONE_BIT]    = 1'b1;
    wb_status[ERR_W-1:0]   = frm_err;

    base_d = base_we ? base_idx : base_q;

    cur_d = cur_q;
    if (base_we)                       cur_d = base_idx;
    else if (accept) begin
      if (cur_status[END_BIT])         cur_d = base_q;
      else if (cur_q == LAST_IDX)      cur_d = '0;
      else                             cur_d = cur_q + 1'b1;
    end

    halt_d = full_hit ? 1'b1 : (halt_clr ? 1'b0 : halt_q);
    busy_d = full_hit ? 1'b1 : (busy_clr ? 1'b0 : busy_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cur_q  <= '0;
      halt_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      base_q <= base_d;
      cur_q  <= cur_d;
      halt_q <= halt_d;
      busy_q <= busy_d;
    end
  end

  assign cur_idx  = cur_q;
  assign busy_evt = busy_q;
  assign halted   = halt_q;

  // R5: busy event only appears together with the halt
  p_busy_with_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> halt_q);
  // R8: halt persists until a restart pulse
  p_halt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !halt_clr) |=> halt_q);
  // R6: no index movement while halted
  p_idx_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_q && !base_we) |=> $stable(cur_q));
  // R3: an accepted frame at a ring-end entry returns to the base
  p_wrap_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cur_status[END_BIT] && !base_we) |=> (cur_q == $past(base_q)));
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ERR_W  = 6,
  parameter int DROP_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [IDX_W-1:0]  sw_idx,
  input  logic [15:0]       sw_status,
  input  logic [15:0]       sw_len,
  input  logic [31:0]       sw_ptr,
  input  logic [IDX_W-1:0]  sw_rd_idx,
  output logic [15:0]       sw_rd_status,
  output logic [15:0]       sw_rd_len,
  output logic [31:0]       sw_rd_ptr,
  input  logic              base_we,
  input  logic [IDX_W-1:0]  base_idx,
  input  logic              busy_clr,
  input  logic              halt_clr,
  input  logic              frm_valid,
  input  logic [15:0]       frm_len,
  input  logic [ERR_W-1:0]  frm_err,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              busy_evt,
  output logic              halted,
  output logic [DROP_W-1:0] drop_cnt
);
  rxr_desc_t        sw_wdata, rd_data;
  logic             wb_we, drop_evt;
  logic [15:0]      wb_status, wb_len, cur_status;

  assign sw_wdata = '{status: sw_status, len: sw_len, ptr: sw_ptr};

  rxr_desc_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .sw_we(sw_we), .sw_idx(sw_idx), .sw_wdata(sw_wdata),
    .wb_we(wb_we), .wb_idx(cur_idx), .wb_status(wb_status), .wb_len(wb_len),
    .eng_idx(cur_idx), .eng_status(cur_status),
    .rd_idx(sw_rd_idx), .rd_data(rd_data)
  );

  rxr_ctrl #(.DEPTH(DEPTH), .ERR_W(ERR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .base_idx(base_idx),
    .busy_clr(busy_clr), .halt_clr(halt_clr),
    .frm_valid(frm_valid), .frm_len(frm_len), .frm_err(frm_err),
    .cur_status(cur_status),
    .wb_we(wb_we), .wb_status(wb_status), .wb_len(wb_len),
    .cur_idx(cur_idx), .busy_evt(busy_evt), .halted(halted),
    .drop_evt(drop_evt)
  );

  rxr_drop_ctr #(.DROP_W(DROP_W)) u_drop (
    .clk(clk), .rst_n(rst_n), .drop_evt(drop_evt), .drop_cnt(drop_cnt)
  );

  assign sw_rd_status = rd_data.status;
  assign sw_rd_len    = rd_data.len;
  assign sw_rd_ptr    = rd_data.ptr;

  // R1: nothing is halted or busy in the first cycle after reset release
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy_evt && !halted));
endmodule

// File: tb/tb_rxr_engine.sv
module tb_rxr_engine;
  localparam int DEPTH = 8, ERR_W = 6, DROP_W = 8, IDX_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sw_we = 0, base_we = 0, busy_clr = 0, halt_clr = 0, frm_valid = 0;
  logic [IDX_W-1:0] sw_idx = '0, sw_rd_idx = '0, base_idx = '0, cur_idx;
  logic [15:0] sw_status = '0, sw_len = '0, frm_len = '0, sw_rd_status, sw_rd_len;
  logic [31:0] sw_ptr = '0, sw_rd_ptr;
  logic [ERR_W-1:0] frm_err = '0;
  logic busy_evt, halted;
  logic [DROP_W-1:0] drop_cnt;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rxr_engine #(.DEPTH(DEPTH), .ERR_W(ERR_W), .DROP_W(DROP_W)) dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sw_put(int idx, logic [15:0] st, logic [15:0] ln, logic [31:0] p);
    @(negedge clk);
    sw_we = 1; sw_idx = IDX_W'(idx); sw_status = st; sw_len = ln; sw_ptr = p;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic frame(logic [15:0] ln, logic [ERR_W-1:0] er);
    @(negedge clk);
    frm_valid = 1; frm_len = ln; frm_err = er;
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic pulse_busy_clr();
    @(negedge clk); busy_clr = 1; @(negedge clk); busy_clr = 0;
  endtask

  task automatic pulse_halt_clr();
    @(negedge clk); halt_clr = 1; @(negedge clk); halt_clr = 0;
  endtask

  task automatic check_ent(string req, int idx, logic [15:0] st, logic [15:0] ln, logic [31:0] p);
    sw_rd_idx = IDX_W'(idx);
    #1;
    check({req, " status"}, 32'(sw_rd_status), 32'(st));
    check({req, " length"}, 32'(sw_rd_len), 32'(ln));
    check({req, " pointer"}, sw_rd_ptr, p);
  endtask

  task automatic t_reset();
    check("R1 cur_idx", 32'(cur_idx), 0);
    check("R1 busy", 32'(busy_evt), 0);
    check("R1 halted", 32'(halted), 0);
    check("R1 drops", 32'(drop_cnt), 0);
    check_ent("R1 entry", 5, 16'h0, 16'h0, 32'h0);
  endtask

  task automatic t_arm_ring();
    for (int i = 0; i < 4; i++)
      sw_put(i, (i == 3) ? 16'hA000 : 16'h8000, 16'h0, 32'h1000 + 32'(i) * 32'h100);
  endtask

  task automatic t_good();
    frame(16'd64, '0);
    check_ent("R2 R4 good", 0, 16'h0800, 16'd64, 32'h1000);
    check("R3 advance", 32'(cur_idx), 1);
  endtask

  task automatic t_errored();
    frame(16'd1518, 6'h05);
    check_ent("R2 err", 1, 16'h0805, 16'd1518, 32'h1100);
    check("R3 advance", 32'(cur_idx), 2);
  endtask

  task automatic t_wrap();
    frame(16'd70, 6'h20);
    check_ent("R2 err high", 2, 16'h0820, 16'd70, 32'h1200);
    frame(16'd80, '0);
    check_ent("R2 end kept", 3, 16'h2800, 16'd80, 32'h1300);
    check("R3 wrap to base", 32'(cur_idx), 0);
  endtask

  task automatic t_full();
    frame(16'd90, '0);
    check("R5 busy", 32'(busy_evt), 1);
    check("R5 halted", 32'(halted), 1);
    check("R5 idx kept", 32'(cur_idx), 0);
    check_ent("R5 entry kept", 0, 16'h0800, 16'd64, 32'h1000);
    check("R6 first drop", 32'(drop_cnt), 1);
  endtask

  task automatic t_halted_drop();
    sw_put(0, 16'h8000, 16'h0, 32'h1000);
    frame(16'd99, '0);
    check_ent("R6 entry untouched", 0, 16'h8000, 16'h0, 32'h1000);
    check("R6 idx kept", 32'(cur_idx), 0);
    check("R6 drops", 32'(drop_cnt), 2);
  endtask

  task automatic t_busy_clear();
    pulse_busy_clr();
    check("R8 busy cleared", 32'(busy_evt), 0);
    check("R8 still halted", 32'(halted), 1);
  endtask

  task automatic t_restart();
    pulse_halt_clr();
    check("R9 resumed", 32'(halted), 0);
    frame(16'd100, '0);
    check_ent("R9 retry same entry", 0, 16'h0800, 16'd100, 32'h1000);
    check("R9 advance", 32'(cur_idx), 1);
    check("R9 drops unchanged", 32'(drop_cnt), 2);
  endtask

  task automatic t_base();
    sw_put(6, 16'hA000, 16'h0, 32'h2600);
    @(negedge clk); base_we = 1; base_idx = 3'd6; @(negedge clk); base_we = 0;
    check("R10 idx loaded", 32'(cur_idx), 6);
    frame(16'd128, '0);
    check_ent("R10 entry", 6, 16'h2800, 16'd128, 32'h2600);
    check("R10 wrap to new base", 32'(cur_idx), 6);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 300; i++) frame(16'd60, '0);
    check("R7 saturated", 32'(drop_cnt), 255);
    check("R7 halted", 32'(halted), 1);
  endtask

  initial begin
    fork
      begin
        #8000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_arm_ring();
    t_good();
    t_errored();
    t_wrap();
    t_full();
    t_halted_drop();
    t_busy_clear();
    t_restart();
    t_base();
    t_saturate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule